// File: doc/BRIEF.md
# I2S Transmit Serializer

This block is the transmit side of a stereo audio serial port, acting as clock provider. It runs from the master clock `clk`. From an 8-bit divide setting it generates the serial bit clock `sclk`, and it also drives the channel-select line `ws`. It takes 32-bit words from the read port of an external show-ahead FIFO, one word per channel slot, left before right. It sends the low bits of each word, most significant bit first, in standard I2S framing: data changes on the falling edge of `sclk`, and `ws` switches one bit before the first bit of the slot it names.

A small state machine controls the block. It has three states:
- `IDLE`: all lines are low.
- `PRIME`: one frame of silence is sent after transmit is enabled.
- `STREAM`: FIFO data is sent.

It has these transitions:
- IDLE→PRIME on `tx_en`.
- PRIME→STREAM at the end of the silent frame while `tx_en` is still high.
- PRIME→IDLE or STREAM→IDLE at a frame end once `tx_en` has dropped.

The divide setting and the resolution are captured at the IDLE→PRIME step. A master clock of 256 times the sample rate with ratio 0 gives 32-bit slots. The same master clock with ratio 2 gives 16-bit slots.

Top module: `i2s_tx_serializer`

## Requirements
- R1: While running, `sclk` is high for ratio+2 master-clock cycles and low for ratio+2 cycles, so its period is 2*(ratio+2) cycles. In IDLE, `sclk` is held low.
- R2: `ratio` and `res` are captured in the cycle in which transmit starts. Changing them while the block runs has no effect on clock period or slot length until the next start.
- R3: Every channel slot lasts W bit clocks. W equals `res` when `res` is between 2 and 32 inclusive. Any other `res` value gives W = 32.
- R4: After a start, the first frame is all zeros: a left slot, then a right slot. No FIFO word is taken during this frame.
- R5: In STREAM, words are taken from the FIFO in order, with the first one placed in a left slot and later ones alternating right, left. Each slot carries bits W-1 down to 0 of its word, MSB first. Bits above W-1 are discarded.
- R6: `ws` is 0 for the left channel and 1 for the right channel. It switches at the falling `sclk` edge that starts the last bit of the preceding slot. `sd` and `ws` change only when `sclk` falls.
- R7: When a STREAM slot starts with `fifo_empty` high, the slot carries zeros and `underrun` is high for exactly that one cycle. No word is popped.
- R8: `fifo_pop` is a one-cycle pulse, raised only when `fifo_empty` is low. The word on `fifo_rdata` in that cycle is the word that gets sent.
- R9: After `tx_en` falls, transmission continues to the end of the current right slot. Then `sclk`, `ws` and `sd` return low and stay low, and no more words are popped.
- R10: During and right after reset, `sclk`, `ws`, `sd`, `fifo_pop` and `underrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Bit-clock divide setting; half period is ratio+2 cycles |
| res | input | 6 | Sample width in bits |
| fifo_rdata | input | 32 | Head word of the show-ahead FIFO |
| fifo_empty | input | 1 | FIFO has no word |
| fifo_pop | output | 1 | Consume the head word this cycle |
| sclk | output | 1 | Serial bit clock |
| ws | output | 1 | Channel select, 0 = left |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Slot started with an empty FIFO |

## Verification
Two situations are hardest to reach from the ports:
- the stop at a frame boundary while the FIFO is partly drained;
- a slot that begins with the FIFO empty partway through a stream.

To reach them, the bench loads fewer or more words than the data slots it requests. It drops `tx_en` as soon as the left word of the last wanted frame has been decoded, so the stop lands on the following right slot. A receiver model in the bench rebuilds words from `sclk`, `ws` and `sd` and checks them. The sweep covers several ratio and width pairs, including the minimum width, out-of-range widths and a configuration change in mid-stream.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2
    } tx_state_e;
endpackage

// File: rtl/i2s_tx_clkdiv.sv
module i2s_tx_clkdiv #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               sclk,
    output logic               fall_tick
);
    localparam int HALF_W = RATIO_W + 1;

    logic [HALF_W-1:0] cnt_q;
    logic [HALF_W-1:0] last_cnt;
    logic              at_last;

    // half period is ratio+2 cycles: count 0 .. ratio+1
    assign last_cnt  = HALF_W'(ratio) + HALF_W'(1);
    assign at_last   = (cnt_q == last_cnt);
    assign fall_tick = run && at_last && sclk;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (at_last) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + HALF_W'(1);
        end
    end
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter #(
    parameter int WORD_W  = 32,
    parameter int WIDTH_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WORD_W-1:0]  load_word,
    input  logic [WIDTH_W-1:0] width,
    output logic               sd,
    output logic               slot_end,
    output logic               pre_end
);
    logic [WORD_W-1:0]  sh_q;
    logic [WIDTH_W-1:0] bit_q;

    assign sd       = sh_q[WORD_W-1];
    assign slot_end = (bit_q == width - WIDTH_W'(1));
    assign pre_end  = (bit_q == width - WIDTH_W'(2));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            bit_q <= '0;
        end else if (load) begin
            // left-align the low 'width' bits so the MSB leaves first
            sh_q  <= load_word << (WORD_W - int'(width));
            bit_q <= '0;
        end else if (step) begin
            sh_q  <= sh_q << 1;
            bit_q <= bit_q + WIDTH_W'(1);
        end
    end
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int RATIO_W = 8,
    parameter int RES_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   res,
    input  logic [WORD_W-1:0]  fifo_rdata,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               sclk,
    output logic               ws,
    output logic               sd,
    output logic               underrun
);
    localparam int WIDTH_W = $clog2(WORD_W + 1);

    tx_state_e          state_q, state_d;
    logic [RATIO_W-1:0] ratio_q;
    logic [WIDTH_W-1:0] width_q;
    logic [WIDTH_W-1:0] width_in;
    logic               chan_q;
    logic               ws_q;
    logic               fall_tick, slot_end, pre_end;
    logic               start, frame_end, slot_load, load_data;
    logic [WORD_W-1:0]  next_word;

    assign width_in = (int'(res) >= 2 && int'(res) <= WORD_W) ? WIDTH_W'(res)
                                                              : WIDTH_W'(WORD_W);

    assign start     = (state_q == ST_IDLE) && tx_en;
    assign frame_end = fall_tick && slot_end && chan_q;
    assign slot_load = start || (fall_tick && slot_end);
    assign load_data = fall_tick && slot_end && (state_d == ST_STREAM);
    assign fifo_pop  = load_data && !fifo_empty;
    assign underrun  = load_data && fifo_empty;
    assign next_word = fifo_pop ? fifo_rdata : '0;
    assign ws        = ws_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tx_en) state_d = ST_PRIME;
            ST_PRIME:  if (frame_end) state_d = tx_en ? ST_STREAM : ST_IDLE;
            ST_STREAM: if (frame_end && !tx_en) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs: channel tracking, frame select and captured configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= 1'b0;
            ws_q    <= 1'b0;
            ratio_q <= '0;
            width_q <= WIDTH_W'(WORD_W);
        end else if (start) begin
            chan_q  <= 1'b0;
            ws_q    <= 1'b0;
            ratio_q <= ratio;
            width_q <= width_in;
        end else if (fall_tick) begin
            if (slot_end)     chan_q <= ~chan_q;
            else if (pre_end) ws_q   <= ~chan_q;
        end
    end

    i2s_tx_clkdiv #(.RATIO_W(RATIO_W)) u_clkdiv (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q != ST_IDLE),
        .ratio     (ratio_q),
        .sclk      (sclk),
        .fall_tick (fall_tick)
    );

    i2s_tx_shifter #(.WORD_W(WORD_W), .WIDTH_W(WIDTH_W)) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_load),
        .step      (fall_tick && !slot_end),
        .load_word (next_word),
        .width     (width_q),
        .sd        (sd),
        .slot_end  (slot_end),
        .pre_end   (pre_end)
    );
endmodule

// File: rtl/i2s_tx_checker.sv
module i2s_tx_checker
    import i2s_tx_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int WIDTH_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic               ws,
    input logic               sd,
    input logic               fifo_pop,
    input logic               fifo_empty,
    input logic               underrun,
    input tx_state_e          state_q,
    input logic [RATIO_W-1:0] ratio_q,
    input logic [WIDTH_W-1:0] width_q
);
    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> !fifo_empty); // R8

    AST_POP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |=> !fifo_pop); // R8

    AST_UNDERRUN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (fifo_empty && !fifo_pop)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!sclk && !ws && !sd && !fifo_pop)); // R9

    AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> ($stable(sd) && $stable(ws))); // R6

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE)
            |-> ($stable(ratio_q) && $stable(width_q))); // R2
endmodule

bind i2s_tx_serializer i2s_tx_checker #(.RATIO_W(RATIO_W), .WIDTH_W(WIDTH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .ws         (ws),
    .sd         (sd),
    .fifo_pop   (fifo_pop),
    .fifo_empty (fifo_empty),
    .underrun   (underrun),
    .state_q    (state_q),
    .ratio_q    (ratio_q),
    .width_q    (width_q)
);

// File: tb/test_i2s_tx_serializer.sv
`timescale 1ns/1ps
module test_i2s_tx_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic [7:0]  cfg_ratio = '0;
    logic [5:0]  cfg_res = 6'd32;
    logic [31:0] fifo_rdata;
    logic        fifo_empty;
    logic        fifo_pop, sclk, ws, sd, underrun;

    always #2.5 clk = ~clk;

    // show-ahead FIFO model
    logic [31:0] mem [0:63];
    int          fill = 0;
    int          rd_ptr = 0;
    logic        fifo_clr = 1'b0;
    assign fifo_empty = (rd_ptr >= fill);
    assign fifo_rdata = (rd_ptr < 64) ? mem[rd_ptr] : 32'd0;
    always @(posedge clk) begin
        if (fifo_clr)      rd_ptr <= 0;
        else if (fifo_pop) rd_ptr <= rd_ptr + 1;
    end

    i2s_tx_serializer i_i2s_tx_serializer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ratio(cfg_ratio), .res(cfg_res),
        .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
        .sclk(sclk), .ws(ws), .sd(sd), .underrun(underrun)
    );

    // receiver model: samples on rising sclk, word ends where ws changes
    logic        mon_clr = 1'b0;
    int          per_exp = 4;
    int          cyc = 0, last_rise = 0, per_err = 0, pop_cnt = 0, und_cnt = 0;
    int          dec_cnt = 0, cur_len = 0;
    bit          have_rise = 0;
    logic        sclk_prev = 1'b0, ws_prev = 1'b0;
    logic [31:0] cur = '0;
    logic [31:0] dec_word [0:63];
    int          dec_len  [0:63];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            per_err = 0; pop_cnt = 0; und_cnt = 0; dec_cnt = 0; cur_len = 0;
            have_rise = 0; ws_prev = 1'b0; cur = '0;
        end else begin
            if (sclk && !sclk_prev) begin
                if (have_rise && (cyc - last_rise != per_exp)) per_err = per_err + 1;
                have_rise = 1; last_rise = cyc;
                cur = {cur[30:0], sd}; cur_len = cur_len + 1;
                if (ws != ws_prev) begin
                    if (dec_cnt < 64) begin
                        dec_word[dec_cnt] = cur; dec_len[dec_cnt] = cur_len;
                    end
                    dec_cnt = dec_cnt + 1; cur = '0; cur_len = 0;
                end
                ws_prev = ws;
            end
            if (fifo_pop) pop_cnt = pop_cnt + 1;
            if (underrun) und_cnt = und_cnt + 1;
        end
        sclk_prev = sclk;
    end

    int n_checks = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input int c, input int k);
        logic [31:0] v;
        v = 32'h9E3779B9 * 32'(k + 1);
        return v ^ (32'(c) << 24);
    endfunction

    task automatic run_case(input int c, input int ratio, input int res,
                            input int nwords, input int frames, input bit alter);
        int w, nslots, exp_pop, exp_und;
        logic [31:0] mask, expv;
        w = (res >= 2 && res <= 32) ? res : 32;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        for (int k = 0; k < 64; k++) mem[k] = word_of(c, k);
        @(negedge clk);
        fill = nwords; fifo_clr = 1'b1; mon_clr = 1'b1; per_exp = 2 * (ratio + 2);
        repeat (2) @(negedge clk);
        fifo_clr = 1'b0; mon_clr = 1'b0;
        cfg_ratio = 8'(ratio); cfg_res = 6'(res); tx_en = 1'b1;
        if (alter) begin
            repeat (20) @(negedge clk);
            cfg_ratio = 8'd7; cfg_res = 6'd12;   // R2: must be ignored
        end
        while (dec_cnt < 2 * frames - 1) @(negedge clk);
        tx_en = 1'b0;
        repeat (2 * w * 2 * (ratio + 2) + 40) @(negedge clk);
        nslots  = 2 * frames - 2;
        exp_pop = (nwords < nslots) ? nwords : nslots;
        exp_und = nslots - exp_pop;
        chk(dec_cnt == 2 * frames, "R9", "slot count", dec_cnt, 2 * frames);
        chk(per_err == 0, "R1", "sclk period errors", per_err, 0);
        for (int j = 0; j < 2 * frames && j < dec_cnt && j < 64; j++) begin
            if (j < 2) expv = 32'd0;
            else if (j - 2 < nwords) expv = word_of(c, j - 2) & mask;
            else expv = 32'd0;
            chk(dec_len[j] == w, alter ? "R2" : "R3", "slot length", dec_len[j], w);
            chk(dec_word[j] == expv,
                (j < 2) ? "R4" : ((j - 2 < nwords) ? "R5" : "R7"),
                "slot data", dec_word[j], expv);
        end
        chk(pop_cnt == exp_pop, "R8", "pop count", pop_cnt, exp_pop);
        chk(und_cnt == exp_und, "R7", "underrun count", und_cnt, exp_und);
        chk(!sclk && !ws && !sd, "R9", "idle lines", {sclk, ws, sd}, 0);
        repeat (60) @(negedge clk);
        chk(pop_cnt == exp_pop && dec_cnt == 2 * frames, "R9", "quiet after stop",
            pop_cnt, exp_pop);
    endtask

    task automatic run_all;
        for (int k = 0; k < 64; k++) mem[k] = 32'hFFFF_FFFF;
        fill = 8;
        repeat (4) @(negedge clk);
        chk(!sclk && !ws && !sd && !fifo_pop && !underrun, "R10", "outputs in reset",
            {sclk, ws, sd, fifo_pop, underrun}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(!sclk && !ws && !sd && !fifo_pop && !underrun, "R10", "outputs after reset",
            {sclk, ws, sd, fifo_pop, underrun}, 0);
        run_case(1, 0, 32,  6, 4, 1'b0);   // 32-bit slots, exact fill
        run_case(2, 2, 16, 10, 3, 1'b0);   // 16-bit slots, words left over
        run_case(3, 1, 24,  3, 4, 1'b0);   // underrun mid-stream
        run_case(4, 5,  8,  4, 3, 1'b0);
        run_case(5, 0,  2,  4, 3, 1'b0);   // minimum width
        run_case(6, 3,  0,  2, 2, 1'b0);   // out-of-range width -> 32
        run_case(7, 0, 40,  2, 2, 1'b0);   // out-of-range width -> 32
        run_case(8, 1, 16,  4, 3, 1'b1);   // config changed while running
        run_case(9, 4, 12,  5, 1, 1'b0);   // stop during silent frame
    endtask

    initial begin
        bit timed_out = 0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        if (timed_out) begin
            n_checks++; n_err++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule